// File: doc/BRIEF.md
# Burst Column Sequencer for a Synchronous DRAM

This block is the device-side sequencer that turns a column command into a run of per-beat column addresses. A command carries a read/write flag and a 9-bit starting column. The burst length and the wrap order are taken from configuration inputs at the moment the command is accepted. After that, one beat is issued per clock until one of three things happens: the programmed length runs out, a stop request arrives, or a newer command replaces the burst.

Write beats drive an array write-enable on the same cycle as their column address. The data mask can veto an individual write beat. Read beats enter a short delay line whose tap is chosen by the read latency input. The output side therefore sees a read-valid and a mask-qualified output-enable the programmed number of clocks after each read beat's column cycle.

An interleaved full-page setting is not a legal combination. The block runs it as an interleaved burst of eight and records the fault in a sticky flag.

Top module: `sdram_burst_seq`

## Requirements
- R1: A command sampled at a clock edge makes `col_valid` high in the following cycle, with `col_addr` equal to the command's start column; later beats follow on consecutive cycles.
- R2: With `cfg_interleave`=0, beat k of a burst of length N (N = 2, 4 or 8) has address bits below log2(N) equal to (start + k) mod N; the upper bits stay equal to those of the start column.
- R3: With `cfg_interleave`=1, beat k has its low log2(N) bits equal to the start's low bits XOR k; the upper bits are unchanged.
- R4: `cfg_blen` values 4 to 7 with `cfg_interleave`=0 select full page: the address advances by one per beat, wraps from 511 to 0, and keeps going until a stop request or a new command.
- R5: `cfg_blen` encodes the length as 0→1, 1→2, 2→4, 3→8 beats; `col_valid` is low in the cycle after the last beat unless a new command was taken.
- R6: `stop_in` sampled high at an edge without `cmd_valid` ends the burst, so `col_valid` is low in the next cycle; when both are high, the command wins.
- R7: A command accepted at any cycle of a running burst replaces that burst at once; beat 0 of the new burst appears in the next cycle.
- R8: `wr_en` is high exactly in cycles that carry a write beat while `dqm_in` is low in that same cycle.
- R9: `rd_valid` is high exactly L cycles after each read beat's column cycle, with L = 1, 2, 3 for `cfg_rlat` = 1, 2, 3; `cfg_rlat` = 0 acts as 1.
- R10: `rd_oe` follows `rd_valid` but is low for beats whose `dqm_in` was high in their column cycle; read beats already issued still emerge after an interrupting command.
- R11: A command taken with `cfg_interleave`=1 and `cfg_blen` 4 to 7 runs as an interleaved burst of eight and sets `cfg_err` from the next cycle until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col | input | 9 | Starting column of the burst |
| cfg_blen | input | 3 | Burst length code (see R4, R5) |
| cfg_interleave | input | 1 | 0 = sequential wrap, 1 = interleaved wrap |
| cfg_rlat | input | 2 | Read latency in clocks (see R9) |
| stop_in | input | 1 | Burst stop request |
| dqm_in | input | 1 | Per-cycle data mask |
| col_valid | output | 1 | A beat is issued this cycle |
| col_addr | output | 9 | Column address of the current beat |
| wr_en | output | 1 | Array write-enable for the current beat |
| rd_valid | output | 1 | Delayed read-data-valid |
| rd_oe | output | 1 | Delayed, mask-qualified output enable |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest situation to reach is the wrap of a full-page burst from column 511 to 0 while reads are still in the latency pipeline. Starting a full-page read near the top of the page and holding it for more than 512 beats reaches the wrap and then lets the counter lap its own starting point. Interrupting a latency-3 read mid-burst with a write shows in-flight read beats draining while write beats begin. A simultaneous stop and command probes the priority between them.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int BSEQ_COL_W = 9;

  typedef logic [BSEQ_COL_W-1:0] col_t;

  // Low-bit mask selecting the wrapping part of the address.
  function automatic col_t len_mask(input logic [2:0] blen, input logic inter);
    case (blen)
      3'd0:    len_mask = col_t'(0);
      3'd1:    len_mask = col_t'(1);
      3'd2:    len_mask = col_t'(3);
      3'd3:    len_mask = col_t'(7);
      default: len_mask = inter ? col_t'(7) : '1;
    endcase
  endfunction

  function automatic logic is_full(input logic [2:0] blen, input logic inter);
    is_full = blen[2] & ~inter;
  endfunction

  function automatic logic is_illegal(input logic [2:0] blen, input logic inter);
    is_illegal = blen[2] & inter;
  endfunction

  // Address of beat idx: upper bits from start, low bits by wrap order.
  function automatic col_t beat_col(input col_t start, input col_t idx,
                                    input col_t mask, input logic inter);
    col_t low;
    low = inter ? (start ^ idx) : (start + idx);
    beat_col = (start & ~mask) | (low & mask);
  endfunction

endpackage

// File: rtl/bseq_col_gen.sv
module bseq_col_gen
  import bseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_write,
  input  col_t       cmd_col,
  input  logic [2:0] cfg_blen,
  input  logic       cfg_interleave,
  input  logic       stop_in,
  output logic       beat_valid,
  output logic       beat_write,
  output col_t       beat_addr,
  output logic       cfg_err
);

  logic act_q, wr_q, full_q, inter_q, err_q;
  col_t start_q, idx_q, mask_q;
  logic last_beat;

  assign last_beat  = act_q & ~full_q & (idx_q == mask_q);
  assign beat_valid = act_q;
  assign beat_write = wr_q;
  assign beat_addr  = beat_col(start_q, idx_q, mask_q, inter_q);
  assign cfg_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      inter_q <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
    end else if (cmd_valid) begin
      act_q   <= 1'b1;
      wr_q    <= cmd_write;
      start_q <= cmd_col;
      idx_q   <= '0;
      mask_q  <= len_mask(cfg_blen, cfg_interleave);
      inter_q <= cfg_interleave;
      full_q  <= is_full(cfg_blen, cfg_interleave);
      if (is_illegal(cfg_blen, cfg_interleave)) err_q <= 1'b1;
    end else if (stop_in) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (last_beat) act_q <= 1'b0;
      idx_q <= idx_q + col_t'(1);
    end
  end

  // Sequential non-full beats never leave their aligned block.
  assert_block_stay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid) && !$past(cmd_valid) && !inter_q && !full_q)
      |-> ((beat_addr & ~mask_q) == ($past(beat_addr) & ~mask_q)));

  // Full page steps by exactly one, wrapping at the top of the page.
  assert_fullpage_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && full_q && $past(beat_valid) && !$past(cmd_valid))
      |-> (beat_addr == col_t'($past(beat_addr) + col_t'(1))));

  // The configuration error flag never clears outside reset.
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

// File: rtl/bseq_lat_pipe.sv
module bseq_lat_pipe #(
  parameter int LAT_MAX = 3,
  parameter int RLAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RLAT_W-1:0] cfg_rlat,
  input  logic              in_valid,
  input  logic              in_oe,
  output logic              out_valid,
  output logic              out_oe
);

  localparam int SEL_W = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  logic [LAT_MAX-1:0] vq, oq;
  logic [SEL_W-1:0]   sel;

  for (genvar g = 0; g < LAT_MAX; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vq[g] <= 1'b0;
          oq[g] <= 1'b0;
        end else begin
          vq[g] <= in_valid;
          oq[g] <= in_oe;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vq[g] <= 1'b0;
          oq[g] <= 1'b0;
        end else begin
          vq[g] <= vq[g-1];
          oq[g] <= oq[g-1];
        end
      end
    end
  end

  always_comb begin
    int t;
    t = (cfg_rlat == '0) ? 0 : int'(cfg_rlat) - 1;
    if (t > LAT_MAX - 1) t = LAT_MAX - 1;
    sel = SEL_W'(t);
  end

  assign out_valid = vq[sel];
  assign out_oe    = oq[sel];

  // At latency one, read-valid mirrors the previous cycle's read beat.
  assert_lat1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rlat == RLAT_W'(1) && $past(cfg_rlat) == RLAT_W'(1))
      |-> (out_valid == $past(in_valid)));

  // A masked or absent beat never produces an output enable.
  assert_oe_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rlat == RLAT_W'(1) && $past(cfg_rlat) == RLAT_W'(1) && !$past(in_oe))
      |-> !out_oe);

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import bseq_pkg::*;
#(
  parameter int LAT_MAX = 3,
  parameter int RLAT_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic                  cmd_write,
  input  logic [BSEQ_COL_W-1:0] cmd_col,
  input  logic [2:0]            cfg_blen,
  input  logic                  cfg_interleave,
  input  logic [RLAT_W-1:0]     cfg_rlat,
  input  logic                  stop_in,
  input  logic                  dqm_in,
  output logic                  col_valid,
  output logic [BSEQ_COL_W-1:0] col_addr,
  output logic                  wr_en,
  output logic                  rd_valid,
  output logic                  rd_oe,
  output logic                  cfg_err
);

  logic beat_valid, beat_write;
  col_t beat_addr;
  logic beat_rd, beat_oe;

  bseq_col_gen i_col_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_write      (cmd_write),
    .cmd_col        (cmd_col),
    .cfg_blen       (cfg_blen),
    .cfg_interleave (cfg_interleave),
    .stop_in        (stop_in),
    .beat_valid     (beat_valid),
    .beat_write     (beat_write),
    .beat_addr      (beat_addr),
    .cfg_err        (cfg_err)
  );

  assign beat_rd = beat_valid & ~beat_write;
  assign beat_oe = beat_rd & ~dqm_in;

  bseq_lat_pipe #(.LAT_MAX(LAT_MAX), .RLAT_W(RLAT_W)) i_lat_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rlat  (cfg_rlat),
    .in_valid  (beat_rd),
    .in_oe     (beat_oe),
    .out_valid (rd_valid),
    .out_oe    (rd_oe)
  );

  assign col_valid = beat_valid;
  assign col_addr  = beat_addr;
  assign wr_en     = beat_valid & beat_write & ~dqm_in;

  // First beat of any command, interrupting or not, carries the start column.
  assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

  // Stop without a command leaves no beat in the next cycle.
  assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_in && !cmd_valid) |=> !col_valid);

  // A newly taken write command drives write beats next cycle.
  assert_new_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |=> (col_valid && (wr_en == !dqm_in)));

endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [8:0] cmd_col = '0;
  logic [2:0] cfg_blen = '0;
  logic       cfg_interleave = 1'b0;
  logic [1:0] cfg_rlat = 2'd2;
  logic       stop_in = 1'b0, dqm_in = 1'b0;
  logic       col_valid, wr_en, rd_valid, rd_oe, cfg_err;
  logic [8:0] col_addr;

  always #10 clk = ~clk;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .cfg_blen(cfg_blen), .cfg_interleave(cfg_interleave),
    .cfg_rlat(cfg_rlat), .stop_in(stop_in), .dqm_in(dqm_in),
    .col_valid(col_valid), .col_addr(col_addr), .wr_en(wr_en),
    .rd_valid(rd_valid), .rd_oe(rd_oe), .cfg_err(cfg_err)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // Reference state
  bit m_act, m_wr, m_inter, m_err;
  int m_start, m_idx, m_len;
  bit rh[4], oh[4];

  function automatic int exp_addr();
    int blk, off;
    blk = m_start - (m_start % m_len);
    off = m_start % m_len;
    if (m_inter) return blk + (off ^ m_idx);
    return blk + ((off + m_idx) % m_len);
  endfunction

  function automatic int lat_of(input logic [1:0] r);
    return (r == 2'd0) ? 1 : int'(r);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_inter = 0; m_err = 0;
      m_start = 0; m_idx = 0; m_len = 1;
      for (int i = 0; i < 4; i++) begin rh[i] = 0; oh[i] = 0; end
    end else begin
      for (int i = 3; i > 1; i--) begin rh[i] = rh[i-1]; oh[i] = oh[i-1]; end
      rh[1] = m_act && !m_wr;
      oh[1] = m_act && !m_wr && !dqm_in;
      if (cmd_valid) begin
        m_act = 1; m_wr = cmd_write; m_start = int'(cmd_col); m_idx = 0;
        m_inter = cfg_interleave;
        case (cfg_blen)
          3'd0: m_len = 1;
          3'd1: m_len = 2;
          3'd2: m_len = 4;
          3'd3: m_len = 8;
          default: begin
            m_len = cfg_interleave ? 8 : 512;
            if (cfg_interleave) m_err = 1;
          end
        endcase
      end else if (stop_in) begin
        m_act = 0;
      end else if (m_act) begin
        m_idx = m_idx + 1;
        if (m_len == 512) m_idx = m_idx % 512;
        else if (m_idx == m_len) m_act = 0;
      end
    end
  end

  task automatic cmp(input string tag, input string sig, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp(cur_tag, "col_valid", int'(col_valid), int'(m_act));
      if (m_act) cmp(cur_tag, "col_addr", int'(col_addr), exp_addr());
      cmp("R8", "wr_en", int'(wr_en), int'(m_act && m_wr && !dqm_in));
      cmp("R9", "rd_valid", int'(rd_valid), int'(rh[lat_of(cfg_rlat)]));
      cmp("R10", "rd_oe", int'(rd_oe), int'(oh[lat_of(cfg_rlat)]));
      cmp("R11", "cfg_err", int'(cfg_err), int'(m_err));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic issue(input bit w, input int col, input int bl, input bit il);
    cmd_valid = 1; cmd_write = w; cmd_col = 9'(col);
    cfg_blen = 3'(bl); cfg_interleave = il;
    cyc(1);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // reset state
    cmp("R1", "reset col_valid", int'(col_valid), 0);
    cmp("R11", "reset cfg_err", int'(cfg_err), 0);
    cmp("R9", "reset rd_valid", int'(rd_valid), 0);
    rst_n = 1;
    cyc(2);

    cur_tag = "R1"; issue(0, 37, 0, 0); cyc(5);            // length 1 read
    cur_tag = "R5"; issue(0, 100, 1, 0); cyc(5);           // length 2
    cur_tag = "R2"; issue(0, 5, 2, 0); cyc(7);             // seq 4, wrap in block
    cur_tag = "R2"; issue(1, 13, 3, 0);                    // seq 8 write, masked beats
    for (int i = 0; i < 10; i++) begin dqm_in = i[0]; cyc(1); end
    dqm_in = 0; cyc(3);

    cfg_rlat = 2'd3; cyc(4);
    cur_tag = "R3"; issue(0, 6, 3, 1);                     // interleave 8
    for (int i = 0; i < 10; i++) begin dqm_in = (i == 2 || i == 5); cyc(1); end
    dqm_in = 0;
    issue(0, 201, 2, 1); cyc(7);                           // interleave 4

    cur_tag = "R7"; issue(0, 40, 3, 0); cyc(3);            // interrupt read by write
    issue(1, 300, 2, 0); cyc(1);
    issue(0, 77, 3, 1); cyc(2);                            // interrupt write by read, odd cycle
    issue(0, 90, 3, 0); cyc(8);

    cur_tag = "R6"; issue(0, 20, 3, 0); cyc(2);
    stop_in = 1; cyc(1); stop_in = 0; cyc(4);
    issue(0, 50, 3, 0); cyc(1);
    stop_in = 1; cmd_valid = 1; cmd_write = 1; cmd_col = 9'd150; cfg_blen = 3'd2; cfg_interleave = 0;
    cyc(1);
    stop_in = 0; cmd_valid = 0; cyc(6);

    cfg_rlat = 2'd1; cyc(4);
    cur_tag = "R4"; issue(0, 508, 7, 0);                   // full page through the wrap
    for (int i = 0; i < 530; i++) begin dqm_in = (i % 7 == 3); cyc(1); end
    dqm_in = 0;
    cur_tag = "R6"; stop_in = 1; cyc(1); stop_in = 0; cyc(4);

    cfg_rlat = 2'd0; cyc(4);
    cur_tag = "R9"; issue(0, 3, 2, 0); cyc(6);

    cfg_rlat = 2'd2; cyc(4);
    cur_tag = "R11"; issue(0, 260, 5, 1); cyc(10);         // illegal combo runs as 8
    issue(1, 10, 1, 0); cyc(5);                            // flag stays set

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule